// File: doc/BRIEF.md
# I2C Serial Clock Divider

This block produces the serial clock of an I2C master from a faster peripheral clock. While enabled, it alternates between a low phase, in which it pulls SCL down through an open-drain drive, and a released phase. Software sets the timing with three controls: an 11-bit clock-control count, a standard/fast mode select and a duty select that only matters in fast mode. Standard mode gives a 50% duty clock. Fast mode gives either a 1:2 or a 9:16 high-to-low ratio.

After SCL is released, the block waits before it starts timing the high phase. Two things must both have happened: a programmable rise-time count has elapsed, and the sampled SCL line reads high. Because of the second condition, a slave can stretch the clock by holding SCL low. The block also gives a byte engine two one-cycle strobes. One marks where the high phase starts, so data can be sampled there. The other marks where SCL is pulled low, so data can be changed there.

Top module: `scl_clkgen`

## Requirements
- R1: In standard mode (`fast_mode`=0), the high phase and the low phase each last C peripheral cycles. C is the clamped control count (see R4). The duty select has no effect in this mode.
- R2: In fast mode with `duty_sel`=0, the high phase lasts C cycles and the low phase lasts 2*C cycles.
- R3: In fast mode with `duty_sel`=1, the high phase lasts 9*C cycles and the low phase lasts 16*C cycles.
- R4: Outside fast mode with `duty_sel`=1, a control count below 4 is used as 4.
- R5: In fast mode with `duty_sel`=1, a control count of 0 is used as 1.
- R6: Once SCL is released and the line reads high at once, the high phase begins T+1 cycles after release, where T is `trise`. The time from `fall_stb` to `rise_stb` is therefore low length + T + 1.
- R7: If the line is still held low S cycles after release, the high phase begins max(T,S)+1 cycles after release. No `rise_stb` follows a cycle in which `scl_in` reads low.
- R8: `fall_stb` is high for exactly one cycle, the first cycle of each low phase, while `scl_drive_low` is 1. `rise_stb` is high for exactly one cycle, the first cycle of each high phase. The two strobes are never high together.
- R9: From the first edge on which `en` is sampled low, `scl_drive_low`, `rise_stb` and `fall_stb` are 0 and all counters are cleared. When `en` returns high, the next cycle is the first cycle of a low phase, and `fall_stb` is asserted in it.
- R10: While `rst_n` is low (synchronous, active low), `scl_drive_low`, `rise_stb` and `fall_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Runs the clock while high |
| fast_mode | input | 1 | 0 = standard, 1 = fast |
| duty_sel | input | 1 | Fast-mode ratio: 0 = 1:2, 1 = 9:16 |
| ccr | input | 11 | Clock-control count |
| trise | input | 6 | Rise-time count in peripheral cycles |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | 1 = pull SCL low (open drain) |
| rise_stb | output | 1 | One-cycle pulse at start of high phase |
| fall_stb | output | 1 | One-cycle pulse at start of low phase |

## Verification
The assertions assume that `scl_in` reflects the real wired-AND line, so it reads high only after the block has released it. They also assume that `en`, once sampled, is what determines the next cycle. They do not require the timing controls to stay stable, but the period checks only hold if they do. The stimulus therefore changes the mode, duty, count and rise-time inputs only while `en` is low. It models the line as released-and-not-stretched, with a per-test stretch length, so `scl_in` never reads high while the block is pulling it down.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_RISE = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  localparam int unsigned MIN_CNT_NORMAL = 4;
  localparam int unsigned MIN_CNT_FD     = 1;
endpackage

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
  parameter int CCR_W = 11,
  parameter int LEN_W = CCR_W + 4
) (
  input  logic             fast_mode,
  input  logic             duty_sel,
  input  logic [CCR_W-1:0] ccr,
  output logic [LEN_W-1:0] high_len,
  output logic [LEN_W-1:0] low_len
);
  import scl_pkg::*;

  logic             fd_mode;
  logic [CCR_W-1:0] min_cnt;
  logic [CCR_W-1:0] c_eff;
  logic [LEN_W-1:0] c_w;

  assign fd_mode = fast_mode & duty_sel;
  assign min_cnt = fd_mode ? CCR_W'(MIN_CNT_FD) : CCR_W'(MIN_CNT_NORMAL);
  assign c_eff   = (ccr < min_cnt) ? min_cnt : ccr;
  assign c_w     = LEN_W'(c_eff);

  always_comb begin
    if (!fast_mode) begin
      high_len = c_w;
      low_len  = c_w;
    end else if (!duty_sel) begin
      high_len = c_w;
      low_len  = c_w << 1;
    end else begin
      high_len = (c_w << 3) + c_w;
      low_len  = c_w << 4;
    end
  end
endmodule

// File: rtl/scl_rise_wait.sv
module scl_rise_wait #(
  parameter int TR_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [TR_W-1:0] trise,
  input  logic            scl_in,
  output logic            done
);
  logic [TR_W-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      rcnt <= '0;
    end else if (rcnt != {TR_W{1'b1}}) begin
      rcnt <= rcnt + 1'b1;
    end
  end

  assign done = active && (rcnt >= trise) && scl_in;
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl #(
  parameter int LEN_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LEN_W-1:0] high_len,
  input  logic [LEN_W-1:0] low_len,
  input  logic             rise_done,
  output logic             in_rise,
  output logic             drive_low,
  output logic             rise_stb,
  output logic             fall_stb
);
  import scl_pkg::*;

  scl_phase_e       st;
  logic [LEN_W-1:0] cnt;
  logic             low_last;
  logic             high_last;

  assign low_last  = cnt >= (low_len - LEN_W'(1));
  assign high_last = cnt >= (high_len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      st       <= PH_IDLE;
      cnt      <= '0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
      unique case (st)
        PH_IDLE: begin
          st       <= PH_LOW;
          cnt      <= '0;
          fall_stb <= 1'b1;
        end
        PH_LOW: begin
          if (low_last) begin
            st  <= PH_RISE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RISE: begin
          if (rise_done) begin
            st       <= PH_HIGH;
            cnt      <= '0;
            rise_stb <= 1'b1;
          end
        end
        PH_HIGH: begin
          if (high_last) begin
            st       <= PH_LOW;
            cnt      <= '0;
            fall_stb <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign in_rise   = (st == PH_RISE);
  assign drive_low = (st == PH_LOW);
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int CCR_W = 11,
  parameter int TR_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fast_mode,
  input  logic             duty_sel,
  input  logic [CCR_W-1:0] ccr,
  input  logic [TR_W-1:0]  trise,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             rise_stb,
  output logic             fall_stb
);
  localparam int LEN_W = CCR_W + 4;

  logic [LEN_W-1:0] high_len;
  logic [LEN_W-1:0] low_len;
  logic             in_rise;
  logic             rise_done;

  scl_phase_len #(.CCR_W(CCR_W), .LEN_W(LEN_W)) i_len (
    .fast_mode (fast_mode),
    .duty_sel  (duty_sel),
    .ccr       (ccr),
    .high_len  (high_len),
    .low_len   (low_len)
  );

  scl_rise_wait #(.TR_W(TR_W)) i_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (in_rise),
    .trise  (trise),
    .scl_in (scl_in),
    .done   (rise_done)
  );

  scl_phase_ctrl #(.LEN_W(LEN_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .high_len  (high_len),
    .low_len   (low_len),
    .rise_done (rise_done),
    .in_rise   (in_rise),
    .drive_low (scl_drive_low),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb)
  );
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_in,
  input logic scl_drive_low,
  input logic rise_stb,
  input logic fall_stb
);
  // R8: the two strobes never coincide
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  // R8: fall strobe only while the line is pulled low
  p_fall_on_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> scl_drive_low);

  // R8: every pull-down starts with a fall strobe
  p_pull_marked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> fall_stb);

  // R8: strobes last one cycle
  p_fall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb);
  p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> !rise_stb);

  // R6: high phase starts on a released line
  p_rise_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> !scl_drive_low);

  // R7: a line read low blocks the start of the high phase
  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_in |=> !rise_stb);

  // R9: disabled means released and silent
  p_disable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !rise_stb && !fall_stb));

  // R10: outputs idle during reset
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r10: assert (!scl_drive_low && !rise_stb && !fall_stb);
    end
  end
endmodule

bind scl_clkgen scl_clkgen_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .en            (en),
  .scl_in        (scl_in),
  .scl_drive_low (scl_drive_low),
  .rise_stb      (rise_stb),
  .fall_stb      (fall_stb)
);

// File: tb/test_scl_clkgen.sv
module test_scl_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        fast_mode = 1'b0;
  logic        duty_sel = 1'b0;
  logic [10:0] ccr = 11'd10;
  logic [5:0]  trise = 6'd3;
  logic        scl_in;
  logic        scl_drive_low;
  logic        rise_stb;
  logic        fall_stb;

  int unsigned stretch = 0;
  logic [15:0] rel_cnt = '0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  // wired line model: released, and no longer held by a slave
  always_ff @(posedge clk) begin
    if (scl_drive_low) rel_cnt <= '0;
    else if (rel_cnt != 16'hFFFF) rel_cnt <= rel_cnt + 1'b1;
  end
  assign scl_in = !scl_drive_low && (int'(rel_cnt) >= stretch);

  scl_clkgen i_scl_clkgen (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .fast_mode     (fast_mode),
    .duty_sel      (duty_sel),
    .ccr           (ccr),
    .trise         (trise),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .rise_stb      (rise_stb),
    .fall_stb      (fall_stb)
  );

  function automatic int eff_cnt(bit f, bit d, int c);
    int m;
    m = (f && d) ? 1 : 4;
    return (c < m) ? m : c;
  endfunction

  function automatic int exp_high(bit f, bit d, int c);
    int e;
    e = eff_cnt(f, d, c);
    return (f && d) ? 9 * e : e;
  endfunction

  function automatic int exp_low(bit f, bit d, int c);
    int e;
    e = eff_cnt(f, d, c);
    if (!f) return e;
    return d ? 16 * e : 2 * e;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // waits for a strobe; returns cycles waited (-1 on timeout)
  task automatic wait_stb(bit want_rise, output int n, output int lows);
    n = 0;
    lows = 0;
    forever begin
      @(negedge clk);
      n++;
      if (scl_drive_low) lows++;
      if (want_rise ? rise_stb : fall_stb) return;
      if (n > 40000) begin
        n = -1;
        return;
      end
    end
  endtask

  task automatic run_cfg(bit f, bit d, int c, int t, int s, string req);
    int n, lows, ex_l, ex_h, ex_r;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    fast_mode = f;
    duty_sel  = d;
    ccr       = 11'(c);
    trise     = 6'(t);
    stretch   = s;
    en        = 1'b1;
    ex_l = exp_low(f, d, c);
    ex_h = exp_high(f, d, c);
    ex_r = ((t > s) ? t : s) + 1;
    wait_stb(1'b0, n, lows);
    for (int p = 0; p < 2; p++) begin
      // fall_stb visible now (counted as a low cycle)
      wait_stb(1'b1, n, lows);
      check(n == ex_l + ex_r, {req, " fall-to-rise"}, n, ex_l + ex_r);
      check(lows + 1 == ex_l, {req, " low cycles"}, lows + 1, ex_l);
      wait_stb(1'b0, n, lows);
      check(n == ex_h, {req, " high cycles"}, n, ex_h);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n, lows;
    void'($urandom(32'h5C1C_0DE5));
    // R10: reset state
    repeat (3) @(negedge clk);
    check(!scl_drive_low && !rise_stb && !fall_stb, "R10 reset idle",
          {29'd0, scl_drive_low, rise_stb, fall_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!scl_drive_low && !fall_stb, "R9 disabled after reset",
          {30'd0, scl_drive_low, fall_stb}, 0);

    // directed
    run_cfg(0, 0, 10, 3, 0, "R1 std");
    run_cfg(0, 1, 7, 5, 0, "R1 std duty ignored");
    run_cfg(1, 0, 5, 2, 0, "R2 fast 1:2");
    run_cfg(1, 1, 3, 1, 0, "R3 fast 9:16");
    run_cfg(0, 0, 0, 2, 0, "R4 clamp std 0");
    run_cfg(0, 0, 3, 2, 0, "R4 clamp std 3");
    run_cfg(1, 0, 1, 2, 0, "R4 clamp fast 1");
    run_cfg(1, 1, 0, 2, 0, "R5 clamp fast-duty 0");
    run_cfg(0, 0, 6, 0, 0, "R6 trise 0");
    run_cfg(0, 0, 6, 63, 0, "R6 trise max");
    run_cfg(0, 0, 6, 4, 12, "R7 stretch longer");
    run_cfg(1, 0, 4, 9, 3, "R7 stretch shorter");
    run_cfg(0, 0, 2047, 9, 0, "R1 max count");

    // R8: strobe widths
    @(negedge clk);
    en = 1'b0;
    stretch = 0;
    fast_mode = 0; duty_sel = 0; ccr = 11'd5; trise = 6'd1;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check(fall_stb && scl_drive_low, "R9 restart in low phase", {31'd0, fall_stb}, 1);
    @(negedge clk);
    check(!fall_stb, "R8 fall strobe one cycle", {31'd0, fall_stb}, 0);
    wait_stb(1'b1, n, lows);
    @(negedge clk);
    check(!rise_stb && !fall_stb, "R8 rise strobe one cycle", {31'd0, rise_stb}, 0);

    // R9: disable mid-high
    en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(!scl_drive_low && !rise_stb && !fall_stb, "R9 disabled quiet",
            {29'd0, scl_drive_low, rise_stb, fall_stb}, 0);
    end

    // random
    for (int i = 0; i < 40; i++) begin
      bit f, d;
      int c, t, s;
      f = 1'($urandom % 2);
      d = 1'($urandom % 2);
      c = int'($urandom % 64);
      t = int'($urandom % 24);
      s = int'($urandom % 30);
      run_cfg(f, d, c, t, s, !f ? "R1 rnd" : (d ? "R3 rnd" : "R2 rnd"));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule